// File: doc/BRIEF.md
# HDLC Serial Receive Deframer with Packet FIFO

This block turns a one-bit serial line into a stream of packet bytes that a host can read. A clock-enable marks each cycle that carries a line bit. The receiver hunts for the 01111110 delimiter by checking every bit position. Between delimiters it deletes the zeros that the sender stuffed in, assembles bytes least significant bit first and checks the 16-bit frame check sequence. It then writes only the payload bytes into a receive queue. Each queue entry holds a byte and two flags, one for the first byte of a packet and one for the last. The last byte also carries a two-bit result code.

A run of seven ones cancels the packet in progress. A packet whose length is not a whole number of bytes is reported with its own code. When the queue is full, the rest of the packet is dropped and a sticky overrun output goes high until reset. The host reads the oldest entry from the head of the queue and removes it with a pop strobe.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset the queue is empty, `overrun` is low and the receiver is hunting: line bits before the first delimiter produce no entry.
- R2: Inside a packet, a zero that follows five consecutive ones is deleted, and bytes are assembled least significant bit first.
- R3: The first stored byte of every packet has `out_first` = 1, and no other byte of that packet has it.
- R4: On the closing delimiter, the last payload byte gets `out_last` = 1 and a result code. The code is 00 when the CRC-16 residue (preset 0xFFFF, reflected polynomial 0x8408) equals 0xF0B8, and 01 otherwise. Entries that are not last carry code 00.
- R5: The two check-sequence bytes never enter the queue. A packet with fewer than three bytes between delimiters produces no entry.
- R6: Consecutive packets may be separated by a single delimiter, or by two delimiters that share one zero bit.
- R7: Seven consecutive ones abort the packet. The oldest byte still held back is stored as the last byte with code 10, the other held bytes are dropped, and the receiver hunts until the next delimiter.
- R8: A packet that closes with a partial byte pending is closed with code 11.
- R9: A byte that finds the queue full is dropped, together with the rest of its packet, including the closing entry. `overrun` then stays high until reset.
- R10: While `out_valid` is high the head entry is shown and held until `pop` is high at a clock edge. An entry becomes visible exactly two rising edges after the edge that samples the line bit releasing it.
- R11: Cycles with `bit_en` low are ignored, whatever the value of `bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | High in cycles that carry a line bit |
| bit_in | input | 1 | Serial line bit |
| pop | input | 1 | Remove the head entry (ignored when empty) |
| out_valid | output | 1 | Queue holds at least one entry |
| out_data | output | 8 | Head entry payload byte |
| out_first | output | 1 | Head entry is the first byte of a packet |
| out_last | output | 1 | Head entry is the last byte of a packet |
| out_status | output | 2 | Result code of the head entry (valid when last) |
| overrun | output | 1 | Sticky queue overflow indication |

## Verification
The bit stage registers each delimiter, abort or data event on the edge that samples the bit. The byte stage writes into the queue on the next edge, so an entry is readable after the second edge. One check looks at `out_valid` between the first and second edge after a closing delimiter, and again after the second edge, to confirm that timing exactly. Every other packet is followed by three idle cycles before the queue is drained. The head is compared at falling edges, one entry per pop, so no read races the write edge.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W           = 8;
    localparam int STUFF_RUN        = 5;
    localparam int FLAG_RUN         = 6;
    localparam int HOLD_BYTES       = 3;
    localparam int CRC_W            = 16;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL    = 16'h8408;
    localparam logic [CRC_W-1:0] CRC_PRESET       = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_GOOD_RESIDUE = 16'hF0B8;

    typedef enum logic [1:0] {
        PKT_GOOD       = 2'b00,
        PKT_CRC_ERR    = 2'b01,
        PKT_ABORTED    = 2'b10,
        PKT_MISALIGNED = 2'b11
    } pkt_status_e;

    typedef struct packed {
        logic data_vld;
        logic data;
        logic flag;
        logic abort;
    } bit_event_t;

    typedef struct packed {
        logic              first;
        logic              last;
        pkt_status_e       status;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
        logic [CRC_W-1:0] n;
        n = c >> 1;
        if (c[0] ^ b) n = n ^ CRC_POLY_REFL;
        return n;
    endfunction

endpackage

// File: rtl/hdlc_rx_bitproc.sv
module hdlc_rx_bitproc
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    output bit_event_t ev
);
    localparam int RUN_MAX = FLAG_RUN + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam int PEND    = FLAG_RUN + 1;
    localparam int CNT_W   = $clog2(PEND + 1);

    logic [RUN_W-1:0] run;
    logic [PEND-1:0]  pend;
    logic [CNT_W-1:0] fill;

    logic do_push, hit_flag, hit_abort, drop_fill;

    always_comb begin
        do_push   = 1'b0;
        hit_flag  = 1'b0;
        hit_abort = 1'b0;
        drop_fill = 1'b0;
        if (bit_en) begin
            if (bit_in) begin
                if (run == RUN_W'(FLAG_RUN))
                    hit_abort = 1'b1;
                else if (run < RUN_W'(FLAG_RUN))
                    do_push = 1'b1;
            end else begin
                if (run == RUN_W'(FLAG_RUN))
                    hit_flag = 1'b1;
                else if (run < RUN_W'(STUFF_RUN))
                    do_push = 1'b1;
                else if (run == RUN_W'(RUN_MAX))
                    drop_fill = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= '0;
            pend <= '0;
            fill <= '0;
            ev   <= '0;
        end else begin
            ev       <= '0;
            ev.flag  <= hit_flag;
            ev.abort <= hit_abort;
            if (bit_en) begin
                if (!bit_in)
                    run <= '0;
                else if (run != RUN_W'(RUN_MAX))
                    run <= RUN_W'(run + 1'b1);
            end
            if (hit_flag || hit_abort || drop_fill) begin
                fill <= '0;
            end else if (do_push) begin
                pend <= {bit_in, pend[PEND-1:1]};
                if (fill == CNT_W'(PEND)) begin
                    ev.data_vld <= 1'b1;
                    ev.data     <= pend[0];
                end else begin
                    fill <= CNT_W'(fill + 1'b1);
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bit_event_t ev,
    input  logic       fifo_full,
    output logic       wr_en,
    output rx_entry_t  wr_entry,
    output logic       overrun
);
    localparam int HELD_W = $clog2(HOLD_BYTES + 1);
    localparam int BCNT_W = $clog2(BYTE_W);

    logic                    active;
    logic [BYTE_W-2:0]       acc;
    logic [BCNT_W-1:0]       bcnt;
    logic [CRC_W-1:0]        crc;
    logic [HELD_W-1:0]       held;
    logic [BYTE_W-1:0]       hold [HOLD_BYTES];
    logic                    opened;
    logic                    discard;

    logic [BYTE_W-1:0] new_byte;
    logic byte_done, held_full, push_out, close_ok, abort_out, want, spill;
    pkt_status_e status;

    always_comb begin
        new_byte  = {ev.data, acc};
        byte_done = active && ev.data_vld && (bcnt == BCNT_W'(BYTE_W - 1));
        held_full = (held == HELD_W'(HOLD_BYTES));
        push_out  = byte_done && held_full;
        close_ok  = active && ev.flag && held_full;
        abort_out = active && ev.abort && (held != '0);
        want      = push_out || close_ok || abort_out;
        spill     = want && !discard && fifo_full;
        wr_en     = want && !discard && !fifo_full;

        status = PKT_GOOD;
        if (abort_out)
            status = PKT_ABORTED;
        else if (close_ok) begin
            if (bcnt != '0)
                status = PKT_MISALIGNED;
            else if (crc != CRC_GOOD_RESIDUE)
                status = PKT_CRC_ERR;
        end

        wr_entry.first  = !opened;
        wr_entry.last   = close_ok || abort_out;
        wr_entry.status = status;
        wr_entry.data   = hold[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            acc     <= '0;
            bcnt    <= '0;
            crc     <= CRC_PRESET;
            held    <= '0;
            opened  <= 1'b0;
            discard <= 1'b0;
            overrun <= 1'b0;
            for (int k = 0; k < HOLD_BYTES; k++) hold[k] <= '0;
        end else begin
            if (spill) overrun <= 1'b1;
            if (ev.flag || ev.abort) begin
                active  <= ev.flag;
                acc     <= '0;
                bcnt    <= '0;
                crc     <= CRC_PRESET;
                held    <= '0;
                opened  <= 1'b0;
                discard <= 1'b0;
            end else if (active && ev.data_vld) begin
                acc  <= new_byte[BYTE_W-1:1];
                bcnt <= BCNT_W'(bcnt + 1'b1);
                crc  <= crc_step(crc, ev.data);
                if (byte_done) begin
                    if (held_full) begin
                        for (int k = 0; k < HOLD_BYTES - 1; k++) hold[k] <= hold[k+1];
                        hold[HOLD_BYTES-1] <= new_byte;
                        opened <= 1'b1;
                        if (spill) discard <= 1'b1;
                    end else begin
                        for (int k = 0; k < HOLD_BYTES; k++)
                            if (held == HELD_W'(k)) hold[k] <= new_byte;
                        held <= HELD_W'(held + 1'b1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  rx_entry_t wr_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      not_empty,
    output logic      full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rx_entry_t      mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           do_wr, do_pop;

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
    assign do_wr     = wr_en && !full;
    assign do_pop    = pop && not_empty;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr)  wr_ptr <= AW'(wr_ptr + 1'b1);
            if (do_pop) rd_ptr <= AW'(rd_ptr + 1'b1);
            case ({do_wr, do_pop})
                2'b10:   count <= CW'(count + 1'b1);
                2'b01:   count <= CW'(count - 1'b1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       pop,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_last,
    output logic [1:0] out_status,
    output logic       overrun
);
    bit_event_t bit_ev;
    rx_entry_t  wr_entry;
    rx_entry_t  head;
    logic       wr_en;
    logic       fifo_full;

    hdlc_rx_bitproc u_bits (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .ev     (bit_ev)
    );

    hdlc_rx_framer u_frm (
        .clk       (clk),
        .rst       (rst),
        .ev        (bit_ev),
        .fifo_full (fifo_full),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .overrun   (overrun)
    );

    hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .pop       (pop),
        .head      (head),
        .not_empty (out_valid),
        .full      (fifo_full)
    );

    assign out_data   = head.data;
    assign out_first  = head.first;
    assign out_last   = head.last;
    assign out_status = head.status;

endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic       pop,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_first,
    input logic       out_last,
    input logic [1:0] out_status,
    input logic       overrun,
    input logic       ev_data,
    input logic       ev_flag,
    input logic       ev_abort,
    input logic       wr_en,
    input logic       fifo_full
);
    AST_RESET_FLUSH: assert property (@(posedge clk)
        rst |=> (!out_valid && !overrun)); // R1

    AST_NONLAST_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> (out_status == 2'b00)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !fifo_full); // R9

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R9

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !pop) |=> (out_valid && $stable(out_data) && $stable(out_first)
                                 && $stable(out_last) && $stable(out_status))); // R10

    AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> !(ev_data || ev_flag || ev_abort)); // R11

endmodule

bind hdlc_rx_deframer hdlc_rx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .pop        (pop),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_first  (out_first),
    .out_last   (out_last),
    .out_status (out_status),
    .overrun    (overrun),
    .ev_data    (bit_ev.data_vld),
    .ev_flag    (bit_ev.flag),
    .ev_abort   (bit_ev.abort),
    .wr_en      (wr_en),
    .fifo_full  (fifo_full)
);

// File: tb/hdlc_rx_deframer_test.sv
module hdlc_rx_deframer_test;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       pop = 1'b0;
    logic       out_valid, out_first, out_last, overrun;
    logic [7:0] out_data;
    logic [1:0] out_status;

    int checks = 0;
    int errors = 0;
    int tx_ones = 0;
    bit gappy = 1'b0;
    logic [7:0]  pbuf [32];
    logic [11:0] expq [$];

    hdlc_rx_deframer #(.FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .pop(pop),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_status(out_status), .overrun(overrun)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic [15:0] n;
        n = c >> 1;
        if (c[0] ^ b) n = n ^ 16'h8408;
        return n;
    endfunction

    task automatic send_raw(input logic b);
        if (gappy) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = ~b;
        end
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        repeat (6) send_raw(1'b1);
        send_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_data_bit(input logic b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    // payload in pbuf[0..n-1]; FCS appended; optional corruption or trailing bits
    task automatic send_frame(input int n, input bit bad, input int extra, input bit expect_it);
        logic [15:0] c;
        logic [7:0]  b;
        logic [1:0]  code;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < 8; j++) c = crc_bit(c, pbuf[i][j]);
        c = ~c;
        code = bad ? 2'b01 : ((extra != 0) ? 2'b11 : 2'b00);
        for (int i = 0; i < n; i++) begin
            b = pbuf[i];
            if (bad && i == 0) b = b ^ 8'h04;
            send_byte(b);
            if (expect_it)
                expq.push_back({(i == 0), (i == n - 1), ((i == n - 1) ? code : 2'b00), b});
        end
        send_byte(c[7:0]);
        send_byte(c[15:8]);
        for (int e = 0; e < extra; e++) send_data_bit(logic'(e % 2));
    endtask

    task automatic drain(input string req);
        logic [11:0] e;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            pop = 1'b0;
            if (!out_valid) break;
            if (expq.size() == 0) begin
                check(1'b0, req, "unexpected entry",
                      int'({out_first, out_last, out_status, out_data}), 0);
            end else begin
                e = expq.pop_front();
                check({out_first, out_last, out_status, out_data} == e, req, "entry",
                      int'({out_first, out_last, out_status, out_data}), int'(e));
            end
            pop = 1'b1;
        end
        check(expq.size() == 0, req, "missing entries", expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!out_valid, "R1", "valid after reset", out_valid, 0);
        check(!overrun, "R1", "overrun after reset", overrun, 0);

        // R1: bits before any delimiter are ignored
        repeat (12) send_raw(1'b1);
        for (int i = 0; i < 40; i++) send_raw(logic'((i % 3) == 0));
        idle(4);
        check(!out_valid, "R1", "entry while hunting", out_valid, 0);

        // R2 R3 R4 R5: length sweep with stuffing-heavy bytes
        for (int len = 1; len <= 8; len++) begin
            for (int i = 0; i < len; i++) pbuf[i] = 8'((i * 53 + len * 29) & 255);
            pbuf[0] = (len % 2 == 1) ? 8'hFF : 8'h3E;
            pbuf[len / 2] = 8'h7E;
            send_flag();
            send_frame(len, 1'b0, 0, 1'b1);
            send_flag();
            idle(3);
            drain("R2 R3 R4 R5");
        end

        // R4: corrupted payload gives code 01
        for (int len = 1; len <= 4; len++) begin
            for (int i = 0; i < len; i++) pbuf[i] = 8'(8'hA5 + i * 17);
            send_flag();
            send_frame(len, 1'b1, 0, 1'b1);
            send_flag();
            idle(3);
            drain("R4");
        end

        // R5: runt packets store nothing
        send_flag(); send_byte(8'h5A); send_byte(8'hC3); send_flag();
        send_byte(8'h12); send_flag(); send_flag();
        idle(4);
        check(!out_valid, "R5", "runt produced entry", out_valid, 0);

        // R6: single shared delimiter, then two delimiters sharing a zero
        pbuf[0] = 8'h11; pbuf[1] = 8'hF0;
        send_flag(); send_frame(2, 1'b0, 0, 1'b1);
        pbuf[0] = 8'h9C; pbuf[1] = 8'h0F; pbuf[2] = 8'hFF;
        send_flag(); send_frame(3, 1'b0, 0, 1'b1);
        send_flag();
        repeat (6) send_raw(1'b1);
        send_raw(1'b0);
        pbuf[0] = 8'h42;
        send_frame(1, 1'b0, 0, 1'b1);
        send_flag();
        idle(3);
        drain("R6");

        // R7: abort after five bytes, then bytes in hunt, then a clean packet
        send_flag();
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44); send_byte(8'h55);
        repeat (7) send_raw(1'b1);
        tx_ones = 0;
        expq.push_back({1'b1, 1'b0, 2'b00, 8'h11});
        expq.push_back({1'b0, 1'b1, 2'b10, 8'h22});
        send_byte(8'h12); send_byte(8'h34);
        pbuf[0] = 8'h77;
        send_flag(); send_frame(1, 1'b0, 0, 1'b1); send_flag();
        idle(3);
        drain("R7");
        send_flag();
        send_byte(8'h11); send_byte(8'h22);
        repeat (7) send_raw(1'b1);
        tx_ones = 0;
        expq.push_back({1'b1, 1'b1, 2'b10, 8'h11});
        idle(3);
        drain("R7");

        // R8: three stray bits before the closing delimiter
        pbuf[0] = 8'h01; pbuf[1] = 8'h80; pbuf[2] = 8'h5E;
        send_flag(); send_frame(3, 1'b0, 3, 1'b1); send_flag();
        idle(3);
        drain("R8");

        // R10: exact write latency and head hold
        pbuf[0] = 8'hB6;
        send_flag(); send_frame(1, 1'b0, 0, 1'b0); send_flag();
        @(negedge clk);
        bit_en = 1'b0;
        check(!out_valid, "R10", "valid after one edge", out_valid, 0);
        @(negedge clk);
        check(out_valid, "R10", "valid after two edges", out_valid, 1);
        idle(3);
        check({out_first, out_last, out_status, out_data} == {1'b1, 1'b1, 2'b00, 8'hB6},
              "R10", "head held", int'({out_first, out_last, out_status, out_data}),
              int'({1'b1, 1'b1, 2'b00, 8'hB6}));
        expq.push_back({1'b1, 1'b1, 2'b00, 8'hB6});
        drain("R10");

        // R11: gap cycles carry inverted garbage on bit_in
        gappy = 1'b1;
        for (int i = 0; i < 4; i++) pbuf[i] = 8'(8'h3F + i * 64);
        send_flag(); send_frame(4, 1'b0, 0, 1'b1); send_flag();
        gappy = 1'b0;
        idle(3);
        drain("R11");

        // R9: overflow of a 16-entry queue
        check(!overrun, "R9", "overrun before overflow", overrun, 0);
        for (int i = 0; i < 20; i++) pbuf[i] = 8'(i * 7 + 3);
        send_flag(); send_frame(20, 1'b0, 0, 1'b0); send_flag();
        for (int i = 0; i < DEPTH; i++)
            expq.push_back({(i == 0), 1'b0, 2'b00, 8'(i * 7 + 3)});
        idle(3);
        check(overrun, "R9", "overrun after overflow", overrun, 1);
        drain("R9");
        pbuf[0] = 8'hC8; pbuf[1] = 8'h2D;
        send_flag(); send_frame(2, 1'b0, 0, 1'b1); send_flag();
        idle(3);
        drain("R9");
        check(overrun, "R9", "overrun sticky", overrun, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule